// File: doc/BRIEF.md
# Debug Session Status and Breakpoint Controller

This block keeps track of one on-chip debug session from arm to end. It holds the sequencer state code that software reads back, counts trace lines stored since the last arm, and raises a flag once the trace store has wrapped its 64-line depth. When the sequencer reaches its final state, the block can request a breakpoint from the CPU. The request goes out at once when tracing is off. When tracing is on, it waits for the trace-complete indication.

The session is driven by a small state machine with four states. `PH_IDLE` means disarmed. `PH_RUN` means armed and following sequencer steps. `PH_TRACE_WAIT` means the final state was reached with the breakpoint enabled and tracing active, so the block waits for trace completion. `PH_DONE` means the final state was reached and any breakpoint has already been issued.

The transitions are:
- ARM: any state to `PH_RUN` when the arm strobe is seen.
- DISARM: `PH_RUN`, `PH_TRACE_WAIT` or `PH_DONE` to `PH_IDLE`, on either the software disarm or the internal end trigger.
- REACH_FINAL: `PH_RUN` to `PH_TRACE_WAIT` or to `PH_DONE`.
- TRACE_OVER: `PH_TRACE_WAIT` to `PH_DONE`.

A 2-bit bank select steers which of four comparator banks, and which of four auxiliary registers, appear in the register window.

Top module: `dbg_session_ctl`

## Requirements
- R1: After power-on reset, the status byte, armed, line count, breakpoint request and all internal state read zero.
- R2: An arm strobe takes priority over every other session input in the same cycle. In the next cycle, armed is 1, the state code (status bits 2:0) is 001, the line count is 0 and the full flag is 0.
- R3: While armed and before the final state, a step event loads its 3-bit code into the state code. Step events while disarmed, or after the final state, leave it unchanged.
- R4: A software disarm clears armed and keeps the state code it had before the disarm.
- R5: An internal end trigger during a session clears armed and sets the state code to 000. It takes priority over a software disarm in the same cycle.
- R6: Each trace store strobe in a cycle that starts armed, without an arm strobe, adds one to the 7-bit line count. At 127 the count stays at 127.
- R7: The full flag (status bit 7) sets in the cycle the line count reaches 64. It stays set until the next arm strobe or a power-on reset.
- R8: With breakpoint enable 1 and tracing disabled, a step to the final code 100 gives a one-cycle breakpoint request in the next cycle.
- R9: With breakpoint enable 1 and tracing enabled, reaching code 100 gives no request until trace-complete is seen. The one-cycle request then follows in the next cycle.
- R10: With breakpoint enable 0 at the final step, no request is made. At most one request occurs per session, and a new arm is needed for another.
- R11: Bank select value k (0 to 3) drives exactly bit k of the comparator-bank one-hot (banks A to D). It also drives exactly bit k of the auxiliary one-hot: state control 1, 2, 3, then the match flags.
- R12: Status bits 6:3 always read zero. The status byte is an output only.
- R13: A system reset (not power-on) clears armed, the state code and the line count, and leaves the full flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | Other system reset, active low, asynchronous |
| arm_set | input | 1 | One-cycle strobe for a write of one to the arm bit |
| arm_clr | input | 1 | One-cycle strobe for a software disarm |
| int_trig_end | input | 1 | Internal end-of-session trigger |
| step_vld | input | 1 | Sequencer moved to a new state |
| step_code | input | 3 | Code of the new sequencer state |
| trace_store | input | 1 | One trace line stored |
| trace_en | input | 1 | Tracing enabled |
| trace_done | input | 1 | Trace session complete |
| brk_en | input | 1 | Breakpoint enable |
| bank_sel | input | 2 | Comparator bank / auxiliary register select |
| dbg_status | output | 8 | {full, 0000, state code} |
| armed | output | 1 | Session armed |
| line_cnt | output | 7 | Saturating trace line count |
| brk_req | output | 1 | One-cycle breakpoint request |
| cmp_bank_oh | output | 4 | One-hot visible comparator bank |
| aux_reg_oh | output | 4 | One-hot visible auxiliary register |

## Verification
The bench uses the default parameters: a 3-bit state code, final code 100, a 64-line trace depth and four banks. With these values the 7-bit count passes the full threshold at 64 and reaches saturation at 127 within about 130 store strobes. This lets one run cover the full flag setting, saturation, survival through a system reset, and clearing by both arm and power-on reset. The final code 100 lies inside the step range, so both the immediate and the trace-delayed breakpoint paths, as well as the steps ignored after the final state, can be driven directly.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE       = 2'd0,
        PH_RUN        = 2'd1,
        PH_TRACE_WAIT = 2'd2,
        PH_DONE       = 2'd3
    } phase_e;
endpackage

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm #(
    parameter int SC_W       = 3,
    parameter int FINAL_CODE = 4,
    parameter int ARM_CODE   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm_set,
    input  logic            arm_clr,
    input  logic            int_trig_end,
    input  logic            step_vld,
    input  logic [SC_W-1:0] step_code,
    input  logic            brk_en,
    input  logic            trace_en,
    input  logic            trace_done,
    output logic            armed,
    output logic [SC_W-1:0] state_code,
    output logic            brk_req
);
    import dbg_pkg::*;

    localparam logic [SC_W-1:0] FIN_C = SC_W'(FINAL_CODE);
    localparam logic [SC_W-1:0] ARM_C = SC_W'(ARM_CODE);

    phase_e          ph_q, ph_d;
    logic [SC_W-1:0] code_d;
    logic            brk_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // next state
    always_comb begin
        ph_d = ph_q;
        if (arm_set) begin
            ph_d = PH_RUN;
        end else begin
            unique case (ph_q)
                PH_IDLE: ph_d = PH_IDLE;
                PH_RUN: begin
                    if (int_trig_end || arm_clr)           ph_d = PH_IDLE;
                    else if (step_vld && step_code == FIN_C)
                        ph_d = (brk_en && trace_en) ? PH_TRACE_WAIT : PH_DONE;
                end
                PH_TRACE_WAIT: begin
                    if (int_trig_end || arm_clr) ph_d = PH_IDLE;
                    else if (trace_done)         ph_d = PH_DONE;
                end
                PH_DONE: begin
                    if (int_trig_end || arm_clr) ph_d = PH_IDLE;
                end
                default: ph_d = PH_IDLE;
            endcase
        end
    end

    // outputs: state code and breakpoint pulse
    always_comb begin
        code_d = state_code;
        brk_d  = 1'b0;
        if (arm_set) begin
            code_d = ARM_C;
        end else begin
            unique case (ph_q)
                PH_IDLE: ;
                PH_RUN: begin
                    if (int_trig_end) begin
                        code_d = '0;
                    end else if (!arm_clr && step_vld) begin
                        code_d = step_code;
                        if (step_code == FIN_C && brk_en && !trace_en)
                            brk_d = 1'b1;
                    end
                end
                PH_TRACE_WAIT: begin
                    if (int_trig_end)                 code_d = '0;
                    else if (!arm_clr && trace_done)  brk_d  = 1'b1;
                end
                PH_DONE: begin
                    if (int_trig_end) code_d = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_code <= '0;
            brk_req    <= 1'b0;
        end else begin
            state_code <= code_d;
            brk_req    <= brk_d;
        end
    end

    assign armed = (ph_q != PH_IDLE);
endmodule

// File: rtl/dbg_trace_cnt.sv
module dbg_trace_cnt #(
    parameter int LINES = 64,
    parameter int CNT_W = $clog2(LINES) + 1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sess_rst_n,
    input  logic             armed,
    input  logic             arm_set,
    input  logic             store,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] FULL_AT = CNT_W'(LINES);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt;
        if (arm_set)                               cnt_d = '0;
        else if (armed && store && cnt != CNT_MAX) cnt_d = cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge sess_rst_n) begin
        if (!sess_rst_n) cnt <= '0;
        else             cnt <= cnt_d;
    end

    // full flag lives on power-on reset only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       full <= 1'b0;
        else if (arm_set) full <= 1'b0;
        else if (cnt_d >= FULL_AT) full <= 1'b1;
    end
endmodule

// File: rtl/dbg_win_sel.sv
module dbg_win_sel #(
    parameter int BANKS = 4,
    parameter int SEL_W = $clog2(BANKS)
) (
    input  logic [SEL_W-1:0] bank_sel,
    output logic [BANKS-1:0] cmp_oh,
    output logic [BANKS-1:0] aux_oh
);
    for (genvar i = 0; i < BANKS; i++) begin : g_dec
        assign cmp_oh[i] = (bank_sel == SEL_W'(i));
        assign aux_oh[i] = (bank_sel == SEL_W'(i));
    end
endmodule

// File: rtl/dbg_session_ctl.sv
module dbg_session_ctl #(
    parameter int SC_W       = 3,
    parameter int FINAL_CODE = 4,
    parameter int LINES      = 64,
    parameter int BANKS      = 4,
    parameter int STAT_W     = 8,
    parameter int CNT_W      = $clog2(LINES) + 1,
    parameter int SEL_W      = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              arm_set,
    input  logic              arm_clr,
    input  logic              int_trig_end,
    input  logic              step_vld,
    input  logic [SC_W-1:0]   step_code,
    input  logic              trace_store,
    input  logic              trace_en,
    input  logic              trace_done,
    input  logic              brk_en,
    input  logic [SEL_W-1:0]  bank_sel,
    output logic [STAT_W-1:0] dbg_status,
    output logic              armed,
    output logic [CNT_W-1:0]  line_cnt,
    output logic              brk_req,
    output logic [BANKS-1:0]  cmp_bank_oh,
    output logic [BANKS-1:0]  aux_reg_oh
);
    localparam int PAD_W = STAT_W - 1 - SC_W;

    logic            sess_rst_n;
    logic [SC_W-1:0] state_code;
    logic            full;

    assign sess_rst_n = por_n & sys_rst_n;

    dbg_seq_fsm #(.SC_W(SC_W), .FINAL_CODE(FINAL_CODE), .ARM_CODE(1)) u_fsm (
        .clk(clk), .rst_n(sess_rst_n), .arm_set(arm_set), .arm_clr(arm_clr),
        .int_trig_end(int_trig_end), .step_vld(step_vld), .step_code(step_code),
        .brk_en(brk_en), .trace_en(trace_en), .trace_done(trace_done),
        .armed(armed), .state_code(state_code), .brk_req(brk_req)
    );

    dbg_trace_cnt #(.LINES(LINES), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .por_n(por_n), .sess_rst_n(sess_rst_n), .armed(armed),
        .arm_set(arm_set), .store(trace_store), .cnt(line_cnt), .full(full)
    );

    dbg_win_sel #(.BANKS(BANKS), .SEL_W(SEL_W)) u_win (
        .bank_sel(bank_sel), .cmp_oh(cmp_bank_oh), .aux_oh(aux_reg_oh)
    );

    assign dbg_status = {full, {PAD_W{1'b0}}, state_code};
endmodule

// File: rtl/dbg_session_chk.sv
module dbg_session_chk #(
    parameter int SC_W  = 3,
    parameter int BANKS = 4,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             por_n,
    input logic             sys_rst_n,
    input logic             arm_set,
    input logic             arm_clr,
    input logic             int_trig_end,
    input logic             trace_store,
    input logic [7:0]       dbg_status,
    input logic             armed,
    input logic [CNT_W-1:0] line_cnt,
    input logic             brk_req,
    input logic [BANKS-1:0] cmp_bank_oh
);
    p_arm_code_r2: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        arm_set |=> (armed && dbg_status[2:0] == 3'd1));

    p_disarm_keep_r4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (armed && !arm_set && !int_trig_end && arm_clr)
        |=> (!armed && dbg_status[2:0] == $past(dbg_status[2:0])));

    p_trig_clear_r5: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (armed && !arm_set && int_trig_end) |=> (!armed && dbg_status[2:0] == 3'd0));

    p_saturate_r6: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (line_cnt == {CNT_W{1'b1}} && trace_store && !arm_set) |=> (line_cnt == {CNT_W{1'b1}}));

    p_full_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
        (dbg_status[7] && !arm_set) |=> dbg_status[7]);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        brk_req |=> !brk_req);

    p_bank_onehot_r11: assert property (@(posedge clk) disable iff (!por_n)
        $countones(cmp_bank_oh) == 1);
endmodule

bind dbg_session_ctl dbg_session_chk #(.SC_W(SC_W), .BANKS(BANKS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_set(arm_set),
    .arm_clr(arm_clr), .int_trig_end(int_trig_end), .trace_store(trace_store),
    .dbg_status(dbg_status), .armed(armed), .line_cnt(line_cnt),
    .brk_req(brk_req), .cmp_bank_oh(cmp_bank_oh)
);

// File: tb/sim_dbg_session_ctl.sv
module sim_dbg_session_ctl;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic       por_n = 1'b0, sys_rst_n = 1'b1;
    logic       arm_set = 0, arm_clr = 0, int_trig_end = 0, step_vld = 0;
    logic [2:0] step_code = 0;
    logic       trace_store = 0, trace_en = 0, trace_done = 0, brk_en = 0;
    logic [1:0] bank_sel = 0;
    logic [7:0] dbg_status;
    logic       armed, brk_req;
    logic [6:0] line_cnt;
    logic [3:0] cmp_bank_oh, aux_reg_oh;

    dbg_session_ctl u0 (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_set(arm_set),
        .arm_clr(arm_clr), .int_trig_end(int_trig_end), .step_vld(step_vld),
        .step_code(step_code), .trace_store(trace_store), .trace_en(trace_en),
        .trace_done(trace_done), .brk_en(brk_en), .bank_sel(bank_sel),
        .dbg_status(dbg_status), .armed(armed), .line_cnt(line_cnt),
        .brk_req(brk_req), .cmp_bank_oh(cmp_bank_oh), .aux_reg_oh(aux_reg_oh)
    );

    int n_chk = 0, n_fail = 0, n_brk = 0;
    bit finished = 0;

    // behavioural reference: phase 0 idle, 1 running, 2 waiting on trace, 3 done
    int m_armed = 0, m_code = 0, m_cnt = 0, m_full = 0, m_phase = 0, m_brk = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int was_armed;
        if (!por_n) begin
            m_armed = 0; m_code = 0; m_cnt = 0; m_full = 0; m_phase = 0; m_brk = 0;
        end else if (!sys_rst_n) begin
            m_armed = 0; m_code = 0; m_cnt = 0; m_phase = 0; m_brk = 0;
        end else begin
            was_armed = m_armed;
            m_brk = 0;
            if (arm_set) begin
                m_armed = 1; m_code = 1; m_cnt = 0; m_full = 0; m_phase = 1;
            end else begin
                if (was_armed && trace_store && m_cnt < 127) m_cnt++;
                if (m_cnt >= 64) m_full = 1;
                if (was_armed) begin
                    if (int_trig_end) begin
                        m_armed = 0; m_code = 0; m_phase = 0;
                    end else if (arm_clr) begin
                        m_armed = 0; m_phase = 0;
                    end else if (m_phase == 1 && step_vld) begin
                        m_code = step_code;
                        if (step_code == 4) begin
                            if (brk_en && trace_en) m_phase = 2;
                            else begin m_phase = 3; m_brk = brk_en; end
                        end
                    end else if (m_phase == 2 && trace_done) begin
                        m_phase = 3; m_brk = 1;
                    end
                end
            end
        end
    endtask

    task automatic compare();
        chk("R2/R4/R5 armed", armed, m_armed);
        chk("R3 state code", dbg_status[2:0], m_code);
        chk("R12 pad bits", dbg_status[6:3], 0);
        chk("R7 full flag", dbg_status[7], m_full);
        chk("R6 line count", line_cnt, m_cnt);
        chk("R8/R9/R10 brk_req", brk_req, m_brk);
        chk("R11 comparator bank", cmp_bank_oh, 1 << bank_sel);
        chk("R11 aux register", aux_reg_oh, 1 << bank_sel);
        if (brk_req) n_brk++;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        arm_set = 0; arm_clr = 0; int_trig_end = 0; step_vld = 0;
        trace_store = 0; trace_done = 0;
    endtask

    task automatic step_to(int code);
        step_vld = 1; step_code = 3'(code); tick();
    endtask

    initial begin
        @(negedge clk);
        por_n = 0; tick(); tick();
        // R1 reset state
        chk("R1 status after POR", dbg_status, 0);
        por_n = 1; tick();
        // R3 steps ignored while disarmed
        step_to(2);
        // R2 arm, R3 steps, R4 disarm keeps code
        arm_set = 1; tick();
        step_to(2); step_to(3);
        arm_clr = 1; tick();
        chk("R4 kept code", dbg_status[2:0], 3);
        // R5 internal trigger, beats disarm in same cycle
        arm_set = 1; tick(); step_to(2);
        int_trig_end = 1; arm_clr = 1; tick();
        chk("R5 cleared code", dbg_status[2:0], 0);
        // R2 arm wins over trigger in same cycle
        arm_set = 1; int_trig_end = 1; tick();
        // R8 immediate breakpoint, then R10 no second one
        n_brk = 0; brk_en = 1; trace_en = 0;
        step_to(3); step_to(4);
        step_to(5); step_to(4); tick(); tick();
        chk("R10 one pulse per session", n_brk, 1);
        // R9 delayed breakpoint
        n_brk = 0; trace_en = 1;
        arm_set = 1; tick(); step_to(4);
        tick(); tick(); tick();
        chk("R9 held until trace done", n_brk, 0);
        trace_done = 1; tick(); tick(); tick();
        chk("R9 pulse after trace done", n_brk, 1);
        // R10 breakpoint disabled
        n_brk = 0; brk_en = 0; trace_en = 0;
        arm_set = 1; tick(); step_to(4); tick(); tick();
        chk("R10 no pulse when disabled", n_brk, 0);
        // R6 / R7 counting, full and saturation
        arm_set = 1; tick();
        for (int i = 0; i < 135; i++) begin
            trace_store = 1; bank_sel = 2'(i); tick();
        end
        chk("R6 saturated", line_cnt, 127);
        chk("R7 full set", dbg_status[7], 1);
        // R13 system reset keeps full, clears the rest
        sys_rst_n = 0; tick();
        sys_rst_n = 1; tick();
        chk("R13 full survives", dbg_status[7], 1);
        chk("R13 count cleared", line_cnt, 0);
        trace_store = 1; tick();
        // R7 arm clears full
        arm_set = 1; tick();
        chk("R7 full cleared by arm", dbg_status[7], 0);
        for (int i = 0; i < 70; i++) begin trace_store = 1; tick(); end
        // R7 POR clears full
        por_n = 0; tick(); por_n = 1; tick();
        chk("R7 full cleared by POR", dbg_status[7], 0);
        // R11 bank sweep
        for (int k = 0; k < 4; k++) begin bank_sel = 2'(k); tick(); end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule